// File: doc/BRIEF.md
# Keyboard Controller Power-Down Sequencer

This block manages the two sleep depths of a small embedded keyboard microcontroller. A halt request from the instruction decoder puts the controller into a light sleep. Only the arithmetic unit's clock is gated, so the timer and the interrupt logic keep running. A stop request puts it into a deep sleep. The oscillator driver is switched off, which removes every controller clock. Both depths share the same two wake sources: the controller's reset input and a host write into the input data buffer.

When a wake is taken, the block emits a one-cycle resume pulse with an action code. The processor core uses this code to decide whether to call the input-buffer interrupt vector, to continue at the next instruction, or to restart at address zero. A wake from deep sleep first re-enables the oscillator. The block then runs a programmable stabilization counter from its always-on reference clock, and it releases the core and arithmetic clocks only when that counter has expired.

Top module: `kbc_pwr_seq`

## Requirements
- R1: After `por_n` is released, all three enables (`alu_clk_en`, `core_clk_en`, `osc_en`) are 1 and `resume_valid` is 0.
- R2: A halt request while running, with no wake source active, gives `alu_clk_en`=0, `core_clk_en`=1 and `osc_en`=1 from the next cycle on.
- R3: A stop request while running, with no wake source active, gives all three enables at 0 from the next cycle on. Stop wins when halt and stop arrive together.
- R4: A host write (`host_wr`) wakes either sleep depth. The action code is 2 (call the interrupt vector) if `ibf_ie` is 1 in the cycle of the write, and 1 (next instruction) if it is 0.
- R5: `cpu_reset` wakes either sleep depth with action code 3 (restart at address 0). It takes priority over a host write in the same cycle.
- R6: A wake from deep sleep sets `osc_en` to 1 in the next cycle. `core_clk_en` and `alu_clk_en` stay 0 for `stab_count`+1 cycles after the wake edge. Both then return to 1 in the same cycle as the resume pulse.
- R7: A halt or stop request in the same cycle as a wake source leaves the enables at 1 and produces the resume pulse in the next cycle.
- R8: `resume_valid` is a single-cycle pulse per wake. `resume_act` is 0 whenever `resume_valid` is 0.
- R9: While asleep with no wake source, the enables hold their values, and further halt or stop requests have no effect.
- R10: During stabilization, a `cpu_reset` changes the pending action to 3. A host write during stabilization neither restarts nor extends the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| por_n | input | 1 | Asynchronous power-on reset of this block, active low |
| cpu_reset | input | 1 | Controller reset request, a wake source |
| halt_req | input | 1 | Light-sleep request from the instruction decoder |
| stop_req | input | 1 | Deep-sleep request from the instruction decoder |
| host_wr | input | 1 | Host wrote a byte into the input data buffer |
| ibf_ie | input | 1 | Input-buffer-full interrupt enable |
| stab_count | input | CNT_W | Stabilization length in reference cycles (stays 0 for stab_count+1) |
| alu_clk_en | output | 1 | Arithmetic unit clock enable |
| core_clk_en | output | 1 | Whole-controller clock enable |
| osc_en | output | 1 | Oscillator driver enable |
| resume_valid | output | 1 | One-cycle resume pulse |
| resume_act | output | 2 | 1 next instruction, 2 interrupt call, 3 restart at 0, 0 idle |

## Verification
A wrong sleep state shows at once on the three enable outputs, one cycle after the request edge. Each state has its own pattern of enables, except stabilization, which differs from deep sleep only by `osc_en`. A wrong latched action or a mis-prioritised wake shows only on the resume pulse, so every wake is checked on the single cycle in which that pulse appears. An off-by-one in the stabilization counter moves the return of `core_clk_en` by one cycle. The bench sweeps counter lengths from 0 to the maximum and checks that exact cycle.

// File: rtl/kbc_pwr_pkg.sv
package kbc_pwr_pkg;
   typedef enum logic [1:0] {
      PS_RUN    = 2'd0,
      PS_DOZE   = 2'd1,
      PS_DEEP   = 2'd2,
      PS_SETTLE = 2'd3
   } pwr_state_e;

   typedef enum logic [1:0] {
      RA_NONE    = 2'd0,
      RA_NEXT    = 2'd1,
      RA_VECTOR  = 2'd2,
      RA_RESTART = 2'd3
   } resume_e;
endpackage

// File: rtl/kbc_wake_arb.sv
module kbc_wake_arb
   import kbc_pwr_pkg::*;
(
   input  logic    cpu_reset,
   input  logic    host_wr,
   input  logic    ibf_ie,
   output logic    wake,
   output resume_e wake_act
);
   // reset outranks a host write when both are present
   always_comb begin
      wake     = cpu_reset | host_wr;
      wake_act = RA_NONE;
      if (cpu_reset)
         wake_act = RA_RESTART;
      else if (host_wr)
         wake_act = ibf_ie ? RA_VECTOR : RA_NEXT;
   end
endmodule

// File: rtl/kbc_stab_timer.sv
module kbc_stab_timer #(
   parameter int  CNT_W   = 10,
   parameter bit  STAB_EN = 1'b1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             expired
);
   generate
      if (STAB_EN) begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
               cnt_q <= '0;
            else if (load)
               cnt_q <= load_val;
            else if (run && (cnt_q != '0))
               cnt_q <= cnt_q - 1'b1;
         end
         assign expired = (cnt_q == '0);
      end else begin : g_bypass
         logic unused_tmr;
         assign unused_tmr = ^{clk, por_n, load, load_val, run};
         assign expired    = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/kbc_pwr_fsm.sv
module kbc_pwr_fsm
   import kbc_pwr_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       halt_req,
   input  logic       stop_req,
   input  logic       wake,
   input  resume_e    wake_act,
   input  logic       cpu_reset,
   input  logic       expired,
   output pwr_state_e state,
   output logic       load_tmr,
   output logic       run_tmr,
   output logic       res_vld,
   output resume_e    res_act
);
   pwr_state_e state_q, state_d;
   resume_e    pend_q, pend_d, act_q, act_d;
   logic       vld_q, vld_d;

   always_comb begin
      state_d  = state_q;
      pend_d   = pend_q;
      vld_d    = 1'b0;
      act_d    = RA_NONE;
      load_tmr = 1'b0;
      unique case (state_q)
         PS_RUN: begin
            if (halt_req || stop_req) begin
               if (wake) begin
                  vld_d = 1'b1;
                  act_d = wake_act;
               end else begin
                  state_d = stop_req ? PS_DEEP : PS_DOZE;
               end
            end
         end
         PS_DOZE: begin
            if (wake) begin
               state_d = PS_RUN;
               vld_d   = 1'b1;
               act_d   = wake_act;
            end
         end
         PS_DEEP: begin
            if (wake) begin
               state_d  = PS_SETTLE;
               pend_d   = wake_act;
               load_tmr = 1'b1;
            end
         end
         PS_SETTLE: begin
            if (cpu_reset) pend_d = RA_RESTART;
            if (expired) begin
               state_d = PS_RUN;
               vld_d   = 1'b1;
               act_d   = cpu_reset ? RA_RESTART : pend_q;
            end
         end
         default: state_d = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= PS_RUN;
         pend_q  <= RA_NONE;
         vld_q   <= 1'b0;
         act_q   <= RA_NONE;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
         vld_q   <= vld_d;
         act_q   <= act_d;
      end
   end

   assign state   = state_q;
   assign run_tmr = (state_q == PS_SETTLE);
   assign res_vld = vld_q;
   assign res_act = act_q;
endmodule

// File: rtl/kbc_pwr_seq.sv
module kbc_pwr_seq
   import kbc_pwr_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter bit STAB_EN   = 1'b1,
   parameter int MIN_CNT_W = 10
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             cpu_reset,
   input  logic             halt_req,
   input  logic             stop_req,
   input  logic             host_wr,
   input  logic             ibf_ie,
   input  logic [CNT_W-1:0] stab_count,
   output logic             alu_clk_en,
   output logic             core_clk_en,
   output logic             osc_en,
   output logic             resume_valid,
   output logic [1:0]       resume_act
);
   generate
      if (STAB_EN && (CNT_W < MIN_CNT_W)) begin : g_bad_width
         $error("kbc_pwr_seq: CNT_W below minimum stabilization width");
      end
      if (CNT_W > 32) begin : g_too_wide
         $error("kbc_pwr_seq: CNT_W above 32");
      end
   endgenerate

   logic       wake, expired, load_tmr, run_tmr, res_vld;
   resume_e    wake_act, res_act;
   pwr_state_e state;

   kbc_wake_arb u_arb (
      .cpu_reset (cpu_reset),
      .host_wr   (host_wr),
      .ibf_ie    (ibf_ie),
      .wake      (wake),
      .wake_act  (wake_act)
   );

   kbc_stab_timer #(.CNT_W(CNT_W), .STAB_EN(STAB_EN)) u_tmr (
      .clk      (clk),
      .por_n    (por_n),
      .load     (load_tmr),
      .load_val (stab_count),
      .run      (run_tmr),
      .expired  (expired)
   );

   kbc_pwr_fsm u_fsm (
      .clk       (clk),
      .por_n     (por_n),
      .halt_req  (halt_req),
      .stop_req  (stop_req),
      .wake      (wake),
      .wake_act  (wake_act),
      .cpu_reset (cpu_reset),
      .expired   (expired),
      .state     (state),
      .load_tmr  (load_tmr),
      .run_tmr   (run_tmr),
      .res_vld   (res_vld),
      .res_act   (res_act)
   );

   assign alu_clk_en   = (state == PS_RUN);
   assign core_clk_en  = (state == PS_RUN) || (state == PS_DOZE);
   assign osc_en       = (state != PS_DEEP);
   assign resume_valid = res_vld;
   assign resume_act   = res_act;
endmodule

// File: rtl/kbc_pwr_seq_chk.sv
module kbc_pwr_seq_chk (
   input logic       clk,
   input logic       por_n,
   input logic       cpu_reset,
   input logic       halt_req,
   input logic       stop_req,
   input logic       host_wr,
   input logic       alu_clk_en,
   input logic       core_clk_en,
   input logic       osc_en,
   input logic       resume_valid,
   input logic [1:0] resume_act
);
   a_r2_halt_gates_alu: assert property (@(posedge clk) disable iff (!por_n)
      (alu_clk_en && halt_req && !stop_req && !cpu_reset && !host_wr)
      |=> (!alu_clk_en && core_clk_en && osc_en));

   a_r3_stop_gates_all: assert property (@(posedge clk) disable iff (!por_n)
      (alu_clk_en && stop_req && !cpu_reset && !host_wr)
      |=> (!alu_clk_en && !core_clk_en && !osc_en));

   a_r5_reset_restarts_doze: assert property (@(posedge clk) disable iff (!por_n)
      (!alu_clk_en && core_clk_en && cpu_reset)
      |=> (resume_valid && resume_act == 2'd3));

   a_r6_core_needs_osc: assert property (@(posedge clk) disable iff (!por_n)
      core_clk_en |-> osc_en);

   a_r6_alu_needs_core: assert property (@(posedge clk) disable iff (!por_n)
      alu_clk_en |-> core_clk_en);

   a_r7_same_cycle_wake: assert property (@(posedge clk) disable iff (!por_n)
      (alu_clk_en && (halt_req || stop_req) && (cpu_reset || host_wr))
      |=> (alu_clk_en && resume_valid));

   a_r8_idle_act_zero: assert property (@(posedge clk) disable iff (!por_n)
      !resume_valid |-> (resume_act == 2'd0));

   a_r8_valid_act_set: assert property (@(posedge clk) disable iff (!por_n)
      resume_valid |-> (resume_act != 2'd0));

   a_r9_deep_holds: assert property (@(posedge clk) disable iff (!por_n)
      (!osc_en && !cpu_reset && !host_wr) |=> !osc_en);
endmodule

bind kbc_pwr_seq kbc_pwr_seq_chk u_chk (
   .clk          (clk),
   .por_n        (por_n),
   .cpu_reset    (cpu_reset),
   .halt_req     (halt_req),
   .stop_req     (stop_req),
   .host_wr      (host_wr),
   .alu_clk_en   (alu_clk_en),
   .core_clk_en  (core_clk_en),
   .osc_en       (osc_en),
   .resume_valid (resume_valid),
   .resume_act   (resume_act)
);

// File: tb/tb_kbc_pwr_seq.sv
module tb_kbc_pwr_seq;
   localparam int CNT_W = 10;

   logic             clk = 1'b0;
   logic             por_n = 1'b0;
   logic             cpu_reset = 1'b0, halt_req = 1'b0, stop_req = 1'b0;
   logic             host_wr = 1'b0, ibf_ie = 1'b0;
   logic [CNT_W-1:0] stab_count = '0;
   logic             alu_clk_en, core_clk_en, osc_en, resume_valid;
   logic [1:0]       resume_act;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   kbc_pwr_seq #(.CNT_W(CNT_W)) dut (
      .clk(clk), .por_n(por_n), .cpu_reset(cpu_reset), .halt_req(halt_req),
      .stop_req(stop_req), .host_wr(host_wr), .ibf_ie(ibf_ie),
      .stab_count(stab_count), .alu_clk_en(alu_clk_en),
      .core_clk_en(core_clk_en), .osc_en(osc_en),
      .resume_valid(resume_valid), .resume_act(resume_act)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic chk_en(input string tag, input logic a, input logic c, input logic o);
      chk(tag, {5'd0, alu_clk_en, core_clk_en, osc_en}, {5'd0, a, c, o});
   endtask

   function automatic logic [1:0] exp_act(input int src, input int ib);
      if (src == 1 || src == 2 || src == 3) return 2'd3;
      return (ib != 0) ? 2'd2 : 2'd1;
   endfunction

   task automatic apply_wake(input int src);
      cpu_reset = (src == 1 || src == 2);
      host_wr   = (src == 0 || src == 2);
   endtask

   task automatic clear_in();
      cpu_reset = 1'b0; host_wr = 1'b0; halt_req = 1'b0; stop_req = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int nlist[7] = '{0, 1, 2, 3, 5, 17, 1023};
      @(negedge clk);
      @(negedge clk);
      por_n = 1'b1;
      step();
      // R1 reset state
      chk_en("R1 enables", 1'b1, 1'b1, 1'b1);
      chk("R1 resume_valid", {7'd0, resume_valid}, 8'd0);

      // light sleep sweep: R2 R4 R5 R8 R9
      for (int ib = 0; ib < 2; ib++) begin
         for (int src = 0; src < 3; src++) begin
            ibf_ie = ib[0];
            halt_req = 1'b1;
            step();
            halt_req = 1'b0;
            chk_en("R2 doze enables", 1'b0, 1'b1, 1'b1);
            stop_req = 1'b1;
            step();
            stop_req = 1'b0;
            chk_en("R9 stop ignored in doze", 1'b0, 1'b1, 1'b1);
            step();
            chk_en("R9 doze held", 1'b0, 1'b1, 1'b1);
            apply_wake(src);
            step();
            clear_in();
            chk_en("R4 doze wake enables", 1'b1, 1'b1, 1'b1);
            chk("R4 R5 doze resume", {5'd0, resume_valid, resume_act},
                {5'd0, 1'b1, exp_act(src, ib)});
            step();
            chk("R8 pulse ends", {5'd0, resume_valid, resume_act}, 8'd0);
         end
      end

      // deep sleep sweep: R3 R6 R10
      for (int k = 0; k < 7; k++) begin
         for (int ib = 0; ib < 2; ib++) begin
            for (int src = 0; src < 5; src++) begin
               int nn;
               nn = nlist[k];
               if (src >= 3 && nn == 0) continue;
               stab_count = nn[CNT_W-1:0];
               ibf_ie = ib[0];
               halt_req = (src == 4);
               stop_req = 1'b1;
               step();
               clear_in();
               chk_en("R3 deep enables", 1'b0, 1'b0, 1'b0);
               halt_req = 1'b1;
               step();
               halt_req = 1'b0;
               chk_en("R9 deep held", 1'b0, 1'b0, 1'b0);
               apply_wake(src >= 3 ? 0 : src);
               step();
               clear_in();
               ibf_ie = ~ib[0];
               chk_en("R6 osc first", 1'b0, 1'b0, 1'b1);
               for (int j = 1; j <= nn; j++) begin
                  if (j == 1 && src == 3) cpu_reset = 1'b1;
                  if (j == 1 && src == 4) host_wr = 1'b1;
                  step();
                  clear_in();
                  chk_en("R6 R10 settling", 1'b0, 1'b0, 1'b1);
                  chk("R8 no early pulse", {7'd0, resume_valid}, 8'd0);
               end
               step();
               chk_en("R6 released", 1'b1, 1'b1, 1'b1);
               chk("R6 R10 deep resume", {5'd0, resume_valid, resume_act},
                   {5'd0, 1'b1, exp_act(src, ib)});
               step();
               chk("R8 deep pulse ends", {7'd0, resume_valid}, 8'd0);
            end
         end
      end

      // same-cycle wake with a sleep request: R7 R5
      stab_count = 10'd4;
      for (int req = 0; req < 3; req++) begin
         for (int src = 0; src < 3; src++) begin
            for (int ib = 0; ib < 2; ib++) begin
               ibf_ie   = ib[0];
               halt_req = (req != 1);
               stop_req = (req != 0);
               apply_wake(src);
               step();
               clear_in();
               chk_en("R7 stays awake", 1'b1, 1'b1, 1'b1);
               chk("R7 immediate resume", {5'd0, resume_valid, resume_act},
                   {5'd0, 1'b1, exp_act(src, ib)});
               step();
               chk("R8 same-cycle pulse ends", {7'd0, resume_valid}, 8'd0);
               chk_en("R7 still awake", 1'b1, 1'b1, 1'b1);
            end
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule